// File: doc/BRIEF.md
# Event Status and Interrupt Vector Unit

This unit collects event pulses from the transfer logic of a two-wire serial bus controller and folds them into one interrupt line and two DMA request lines. Each event pulse sets a sticky bit in a 16-bit status word. A 5-bit enable mask selects which of the low five status bits may raise the interrupt. A DMA configuration word routes the receive-ready and transmit-ready bits onto the two request lines.

Software reaches the unit through a plain 16-bit register port with single-cycle write and read strobes. The port is always ready, so there is no back-pressure: a write lands on the clock edge that samples `reg_wr`. Read data is registered and is valid from the edge that samples `reg_rd` until the next read. Reading the vector register returns the 1-based position of the lowest pending enabled event and retires that event in the same edge. This lets an interrupt handler service events one at a time, lowest position first. While the controller enable input is low, every register is held at zero.

Register word addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | enable mask |
| 1 | status |
| 2 | vector |
| 3 | DMA configuration |

Top module: `evt_irq_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, or `ctl_en` is low at a rising edge, the status word, enable mask, DMA configuration and read data all become zero. `irq` and `dma_req` then read low.
- R2: Each `evt_set` bit sets one status bit at the edge that samples it, and that bit stays set. The mapping from `evt_set` bit to status bit is: 0 to 1 (no-acknowledge), 1 to 2 (access ready), 2 to 3 (receive ready), 3 to 4 (transmit ready), 4 to 9 (addressed as slave), 5 to 10 (transmit underflow), 6 to 11 (receive overrun), and 7 to 15 (single byte data).
- R3: A status read (address 1) returns the stored bits with `bus_busy` placed at bit 12. Bit 12 is never stored, so a later read with `bus_busy` low shows bit 12 clear.
- R4: `irq` is high exactly when status bits [4:0] ANDed with the enable mask is nonzero.
- R5: A vector read (address 2) returns the index plus one of the lowest set bit of status[4:0] AND mask, or 0 when that AND is zero.
- R6: A vector read clears the status bit it reported and no other bit. An event pulse in the same edge still sets any other bit, but it loses to the clear on the reported bit.
- R7: A write to the enable mask (address 0) keeps `reg_wdata[4:0]`. Reading the mask returns it zero-extended.
- R8: A write to DMA configuration (address 3) stores only bits 15 (receive DMA enable) and 7 (transmit DMA enable). Writing bit 15 set clears mask bit 3, and writing bit 7 set clears mask bit 4.
- R9: `dma_req[0]` equals status bit 3 while receive DMA is enabled, and `dma_req[1]` equals status bit 4 while transmit DMA is enabled. Each request is low while its DMA enable is clear.
- R10: Writes to the status and vector addresses change no register.
- R11: A read of an address from 4 to 7 returns zero, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_en | input | 1 | Controller enable; low holds all registers at zero |
| evt_set | input | 8 | Event set pulses from the transfer logic |
| bus_busy | input | 1 | Live bus-busy flag, shown in status reads |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 2 | DMA requests: bit 0 receive, bit 1 transmit |

## Verification
An event pulse or a register write is captured at one rising edge. Its effect on the status word, `irq` and `dma_req` is due at the falling edge half a cycle later, and the bench samples there. A read strobe loads `reg_rdata` at the edge that samples it, so the read task raises the strobe at a falling edge and takes the value at the following falling edge. The collision test uses that same single edge: it drives a vector read and event pulses together, then reads status one transaction later to see which bits were retired and which were set.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int REG_W    = 16;
  localparam int MASK_W   = 5;
  localparam int ADDR_W   = 3;
  localparam int EVT_N    = 8;

  localparam int BUSY_POS = 12;
  localparam int RXDMA_POS = 15;
  localparam int TXDMA_POS = 7;
  localparam int RRDY_POS = 3;
  localparam int XRDY_POS = 4;

  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_VECTOR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DMACFG = 3'd3;

  // status bit position for each event strobe
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      4:       return 9;
      5:       return 10;
      6:       return 11;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/evt_lowest_set.sv
module evt_lowest_set #(
  parameter int W = 5,
  localparam int IDX_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [W-1:0]     sel_o,
  output logic [IDX_W-1:0] code_o
);
  // isolate the lowest set bit
  assign sel_o = vec_i & (~vec_i + W'(1));

  always_comb begin
    code_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) code_o = IDX_W'(i + 1);
    end
  end

  // R5
  always_comb begin
    lowest_onehot_chk: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_irq_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int EVT_W = EVT_N,
  localparam int POS_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [EVT_W-1:0] set_evt_i,
  input  logic [W-1:0]     clr_i,
  output logic [W-1:0]     status_o
);
  logic [W-1:0] set_vec;
  logic [W-1:0] status_q;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < EVT_W; i++) begin
      set_vec[POS_W'(evt_pos(i))] = set_vec[POS_W'(evt_pos(i))] | set_evt_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) status_q <= '0;
    else                 status_q <= (status_q | set_vec) & ~clr_i;
  end

  assign status_o = status_q;

  // R6
  vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((status_q & $past(clr_i)) == '0));

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && set_evt_i != '0) |=>
      ((status_q & $past(set_vec & ~clr_i)) == $past(set_vec & ~clr_i)));
endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_irq_pkg::*;
#(
  parameter int MW = MASK_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          wr_mask_i,
  input  logic          wr_dma_i,
  input  logic [DW-1:0] wdata_i,
  output logic [MW-1:0] mask_o,
  output logic [DW-1:0] dma_o
);
  localparam logic [DW-1:0] DMA_KEEP = (DW'(1) << RXDMA_POS) | (DW'(1) << TXDMA_POS);

  logic [MW-1:0] mask_q, mask_d;
  logic [DW-1:0] dma_q, dma_d;

  always_comb begin
    mask_d = mask_q;
    dma_d  = dma_q;
    if (wr_mask_i) mask_d = wdata_i[MW-1:0];
    if (wr_dma_i) begin
      dma_d = wdata_i & DMA_KEEP;
      if (wdata_i[RXDMA_POS]) mask_d[RRDY_POS] = 1'b0;
      if (wdata_i[TXDMA_POS]) mask_d[XRDY_POS] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      mask_q <= '0;
      dma_q  <= '0;
    end else begin
      mask_q <= mask_d;
      dma_q  <= dma_d;
    end
  end

  assign mask_o = mask_q;
  assign dma_o  = dma_q;

  // R8
  rx_dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma_i && !wr_mask_i && wdata_i[RXDMA_POS]) |=> !mask_q[RRDY_POS]);

  // R8
  tx_dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma_i && !wr_mask_i && wdata_i[TXDMA_POS]) |=> !mask_q[XRDY_POS]);
endmodule

// File: rtl/evt_irq_core.sv
module evt_irq_core
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic [EVT_N-1:0]  evt_set,
  input  logic              bus_busy,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic [1:0]        dma_req
);
  localparam int IDX_W = $clog2(MASK_W + 1);

  logic [REG_W-1:0]  status;
  logic [MASK_W-1:0] mask;
  logic [REG_W-1:0]  dma_cfg;
  logic [MASK_W-1:0] pend, pend_sel;
  logic [IDX_W-1:0]  vec_code;
  logic [REG_W-1:0]  clr_bits;
  logic [REG_W-1:0]  rd_mux, rd_status;
  logic [REG_W-1:0]  rdata_q;
  logic              wr_mask, wr_dma, rd_vec;

  assign wr_mask = reg_wr && (reg_addr == A_ENABLE);
  assign wr_dma  = reg_wr && (reg_addr == A_DMACFG);
  assign rd_vec  = reg_rd && (reg_addr == A_VECTOR);

  evt_cfg_regs #(.MW(MASK_W), .DW(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en_i(ctl_en),
    .wr_mask_i(wr_mask), .wr_dma_i(wr_dma), .wdata_i(reg_wdata),
    .mask_o(mask), .dma_o(dma_cfg)
  );

  assign pend = status[MASK_W-1:0] & mask;

  evt_lowest_set #(.W(MASK_W)) u_low (
    .vec_i(pend), .sel_o(pend_sel), .code_o(vec_code)
  );

  assign clr_bits = rd_vec ? REG_W'(pend_sel) : '0;

  evt_status_reg #(.W(REG_W), .EVT_W(EVT_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .en_i(ctl_en),
    .set_evt_i(evt_set), .clr_i(clr_bits), .status_o(status)
  );

  always_comb begin
    rd_status = status;
    rd_status[BUSY_POS] = bus_busy;
    case (reg_addr)
      A_ENABLE: rd_mux = REG_W'(mask);
      A_STATUS: rd_mux = rd_status;
      A_VECTOR: rd_mux = REG_W'(vec_code);
      A_DMACFG: rd_mux = dma_cfg;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ctl_en) rdata_q <= '0;
    else if (reg_rd)       rdata_q <= rd_mux;
  end

  assign reg_rdata  = rdata_q;
  assign irq        = |pend;
  assign dma_req[0] = dma_cfg[RXDMA_POS] & status[RRDY_POS];
  assign dma_req[1] = dma_cfg[TXDMA_POS] & status[XRDY_POS];

  // R5
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && rd_vec && !irq) |=> (reg_rdata == '0));

  // R1
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en) |=> (reg_rdata == '0 && !irq && dma_req == 2'b00));
endmodule

// File: tb/sim_evt_irq_core.sv
module sim_evt_irq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b1;
  logic [7:0]  evt_set = '0;
  logic        bus_busy = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic [1:0]  dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_irq_core u0 (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .evt_set(evt_set),
    .bus_busy(bus_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dma_req(dma_req)
  );

  // {evt, mask, status expected, vector expected, irq expected}
  localparam logic [34:0] TBL [0:5] = '{
    {8'h01, 5'h1F, 16'h0002, 5'd2, 1'b1},
    {8'h84, 5'h08, 16'h8008, 5'd4, 1'b1},
    {8'h70, 5'h1F, 16'h0E00, 5'd0, 1'b0},
    {8'h0A, 5'h10, 16'h0014, 5'd5, 1'b1},
    {8'hFF, 5'h00, 16'h8E1E, 5'd0, 1'b0},
    {8'h0E, 5'h1C, 16'h001C, 5'd3, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt_set = e;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic disable_cycle();
    @(negedge clk);
    ctl_en = 1'b0;
    @(negedge clk);
    ctl_en = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] after;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 mask", v, 16'h0);
    rd(3'd1, v); check("R1 status", v, 16'h0);
    rd(3'd2, v); check("R1 vector", v, 16'h0);
    rd(3'd3, v); check("R1 dmacfg", v, 16'h0);
    check("R1 irq/dreq", {13'b0, irq, dma_req}, 16'h0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      disable_cycle();
      wr(3'd0, {11'b0, TBL[i][26:22]});
      pulse(TBL[i][34:27]);
      check("R4 irq", {15'b0, irq}, {15'b0, TBL[i][0]});
      rd(3'd1, v); check("R2 status", v, TBL[i][21:6]);
      rd(3'd2, v); check("R5 vector", v, {11'b0, TBL[i][5:1]});
      after = TBL[i][21:6];
      if (TBL[i][5:1] != 0) after = after & ~(16'h1 << (TBL[i][5:1] - 1));
      rd(3'd1, v); check("R6 status after vector", v, after);
    end

    // R3 busy inserted, not stored
    disable_cycle();
    pulse(8'h01);
    bus_busy = 1'b1;
    rd(3'd1, v); check("R3 busy shown", v, 16'h1002);
    bus_busy = 1'b0;
    rd(3'd1, v); check("R3 busy not stored", v, 16'h0002);

    // R7 mask width
    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); check("R7 mask keep", v, 16'h001F);

    // R10 writes to status and vector ignored
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    rd(3'd1, v); check("R10 status unchanged", v, 16'h0002);
    rd(3'd0, v); check("R10 mask unchanged", v, 16'h001F);

    // R11 unmapped read and write
    wr(3'd5, 16'hFFFF);
    rd(3'd5, v); check("R11 unmapped read", v, 16'h0);
    rd(3'd1, v); check("R11 status unchanged", v, 16'h0002);

    // R8 DMA config keeps 15 and 7, clears mask bits
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v); check("R8 dma keep", v, 16'h8080);
    rd(3'd0, v); check("R8 mask cleared", v, 16'h0007);

    // R9 dma requests
    pulse(8'h0C);
    check("R9 both dreq", {14'b0, dma_req}, 16'h3);
    check("R4 irq masked rdy", {15'b0, irq}, 16'h1);
    wr(3'd3, 16'h0080);
    check("R9 tx only", {14'b0, dma_req}, 16'h2);
    wr(3'd3, 16'h0000);
    check("R9 none", {14'b0, dma_req}, 16'h0);

    // R6 vector read colliding with event pulses
    disable_cycle();
    wr(3'd0, 16'h001F);
    pulse(8'h03);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd2; evt_set = 8'h05;
    @(negedge clk);
    reg_rd = 1'b0; evt_set = '0;
    check("R6 collide vector", reg_rdata, 16'd2);
    rd(3'd1, v); check("R6 collide status", v, 16'h000C);

    // R1 disable clears and holds through strobes
    wr(3'd3, 16'h8000);
    @(negedge clk);
    ctl_en = 1'b0; evt_set = 8'hFF;
    @(negedge clk);
    evt_set = '0;
    check("R1 disabled irq/dreq", {13'b0, irq, dma_req}, 16'h0);
    ctl_en = 1'b1;
    rd(3'd1, v); check("R1 status cleared", v, 16'h0);
    rd(3'd0, v); check("R1 mask cleared", v, 16'h0);
    rd(3'd3, v); check("R1 dma cleared", v, 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule